// File: doc/BRIEF.md
# Palette-Expanding Raster Pixel Streamer

This block turns a packed 4-bit-per-pixel framebuffer into a stream of 8-bit colour words for a raster display. On every pixel enable of an active line it takes the next nibble of the line, looks it up in a writable 16-entry palette and presents the result as an intensity-plus-RGB word. The word is laid out as intensity in bits 7:6, blue in 5:4, green in 3:2 and red in 1:0. Each byte of framebuffer RAM holds two pixels. By default each line is 416 pixels, so 208 bytes. With the default divider the core clock is divided by 10, which gives an 8 MHz pixel rate from an 80 MHz clock.

A sync generator supplies three control inputs: a frame-start pulse, a line-start pulse and a line-active level. The block owns the framebuffer read port, which is byte-wide and has one cycle of read latency. It fetches each byte one pixel period before the byte is shown. Line n of a frame is read from `FB_BASE + n*LINE_PIXELS/2`.

The output is a stream: `pix_valid` marks the cycles that carry a real pixel. There is no ready input, because a raster cannot wait. The consumer must accept each word in the pixel period in which it appears. Outside the visible pixels the colour word is forced to zero (black).

Top module: `pal_pixel_streamer`

## Requirements
- R1: A pixel enable occurs once every `DIV_CLKS` clock cycles. The counter starts at reset release, and the first enable comes on the `DIV_CLKS`-th rising edge after reset. `pix_color` and `pix_valid` change only on the edge of a pixel enable.
- R2: Suppose `line_start` is pulsed at least 3 cycles before the first pixel enable that sees `line_active` high. Then that enable shows pixel 0 of the line, with `pix_valid` at 1.
- R3: Byte k of a line holds pixels 2k (bits 3:0) and 2k+1 (bits 7:4). The low nibble is shown first.
- R4: Each shown pixel equals the palette entry selected by its nibble. The 8-bit word is laid out as bits 7:6 intensity, 5:4 blue, 3:2 green and 1:0 red.
- R5: `pix_color` is 0 and `pix_valid` is 0 after these pixel enables:
  - an enable where `line_active` is low;
  - an enable after `LINE_PIXELS` pixels of the line have been shown.
- R6: The line counter returns to 0 on `frame_start`. The first read of line n is at `FB_BASE + n*LINE_PIXELS/2`. When `frame_start` and `line_start` come in the same cycle, that line is line 0.
- R7: A fully shown line issues exactly `LINE_PIXELS/2` single-cycle reads at consecutive ascending addresses. Read data is taken one cycle after the cycle in which `fb_rd_en` is high.
- R8: A palette write is used from the next pixel enable onward. A pixel enable in the same cycle as the write still uses the old entry.
- R9: After reset, `pix_color`, `pix_valid` and `fb_rd_en` are 0, and palette entry i holds {i, i} (the nibble repeated).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse at vertical sync: line counter back to 0 |
| line_start | input | 1 | One-cycle pulse before each line: prefetch the first byte |
| line_active | input | 1 | High while the visible part of the line lasts |
| fb_rd_en | output | 1 | Framebuffer read strobe |
| fb_rd_addr | output | ADDR_W | Framebuffer byte address |
| fb_rd_data | input | 8 | Read data, valid one cycle after `fb_rd_en` |
| pal_we | input | 1 | Palette write strobe |
| pal_idx | input | 4 | Palette entry to write |
| pal_color | input | 8 | Colour word to write |
| pix_color | output | 8 | Colour word out, intensity/blue/green/red |
| pix_valid | output | 1 | High while `pix_color` carries a visible pixel |

## Verification
The bench builds the block with `DIV_CLKS=4`, `LINE_PIXELS=12` and `FB_BASE=0x40` in a 12-bit address space. These values keep a whole line, plus its overhang past the pixel limit, within about seventy cycles, so many lines and two frames fit in a short run. The overhang makes the width cut-off reachable, and a shortened line exercises blanking by `line_active`. With `DIV_CLKS=4`, the gap between the two-cycle fetch path and the next pixel enable is only one cycle, so the prefetch timing is close to its limit. Palette writes are spread across an active line, which makes writes coincide with pixel enables.

// File: rtl/pps_pkg.sv
`timescale 1ns/1ps
package pps_pkg;
  typedef logic [7:0] color_t;
  typedef logic [3:0] nib_t;

  // Reset colour of a palette slot: nibble repeated in both halves.
  function automatic color_t reset_entry(input int unsigned i);
    nib_t n;
    n = i[3:0];
    return {n, n};
  endfunction
endpackage

// File: rtl/pps_tick.sv
`timescale 1ns/1ps
module pps_tick #(
  parameter int DIV_CLKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic pe
);
  localparam int CW = $clog2(DIV_CLKS);
  localparam logic [CW-1:0] LAST = CW'(DIV_CLKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                cnt <= cnt + CW'(1);
  end

  assign pe = (cnt == LAST);

  // R1: enables are isolated, never in adjacent cycles
  a_r1_pe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    pe |=> !pe);
endmodule

// File: rtl/pps_palette.sv
`timescale 1ns/1ps
module pps_palette
  import pps_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   we,
  input  nib_t   wr_idx,
  input  color_t wr_color,
  input  nib_t   rd_idx,
  output color_t rd_color
);
  color_t slot [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) slot[i] <= reset_entry(i);
    end else if (we) begin
      slot[wr_idx] <= wr_color;
    end
  end

  // Plain read: a same-edge write lands only after the reader samples.
  assign rd_color = slot[rd_idx];

  // R8: a written entry holds the written colour one cycle later
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> slot[$past(wr_idx)] == $past(wr_color));
endmodule

// File: rtl/pps_fetch.sv
`timescale 1ns/1ps
module pps_fetch
  import pps_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 208,
  parameter int FB_BASE    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              adv,        // a pixel was consumed this cycle
  input  logic              more,       // another byte is still needed in the line
  output logic              fb_rd_en,
  output logic [ADDR_W-1:0] fb_rd_addr,
  input  logic [7:0]        fb_rd_data,
  output nib_t              nibble
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(LINE_BYTES);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(FB_BASE);

  typedef enum logic {TO_CUR, TO_NXT} tgt_e;

  logic [ADDR_W-1:0] line_base, rd_ptr, start_addr;
  logic [7:0]        cur_byte, nxt_byte;
  logic              hi_half;
  tgt_e              tgt, pend_tgt;
  logic              pend;

  assign start_addr = frame_start ? BASE : line_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_base  <= BASE;
      rd_ptr     <= BASE;
      fb_rd_en   <= 1'b0;
      fb_rd_addr <= BASE;
      tgt        <= TO_CUR;
      hi_half    <= 1'b0;
      cur_byte   <= '0;
      nxt_byte   <= '0;
      pend       <= 1'b0;
      pend_tgt   <= TO_CUR;
    end else begin
      if (line_start) begin
        fb_rd_en   <= 1'b1;
        fb_rd_addr <= start_addr;
        rd_ptr     <= start_addr + ADDR_W'(1);
        line_base  <= start_addr + STEP;
        tgt        <= TO_CUR;
        hi_half    <= 1'b0;
      end else begin
        if (frame_start) line_base <= BASE;
        if (adv) begin
          fb_rd_en   <= !hi_half && more;
          fb_rd_addr <= rd_ptr;
          tgt        <= TO_NXT;
          if (!hi_half && more) rd_ptr <= rd_ptr + ADDR_W'(1);
          if (hi_half) cur_byte <= nxt_byte;
          hi_half    <= !hi_half;
        end else begin
          fb_rd_en <= 1'b0;
        end
      end
      // Capture the byte one cycle after the RAM saw the strobe.
      pend     <= fb_rd_en;
      pend_tgt <= tgt;
      if (pend) begin
        if (pend_tgt == TO_CUR) cur_byte <= fb_rd_data;
        else                    nxt_byte <= fb_rd_data;
      end
    end
  end

  assign nibble = hi_half ? cur_byte[7:4] : cur_byte[3:0];

  // R7: reads stay inside the current line's byte span
  a_r7_read_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    fb_rd_en |-> (fb_rd_addr < line_base) && (fb_rd_addr >= line_base - STEP));
  // R7: every read is a single-cycle strobe
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    fb_rd_en |=> !fb_rd_en);
endmodule

// File: rtl/pal_pixel_streamer.sv
`timescale 1ns/1ps
module pal_pixel_streamer
  import pps_pkg::*;
#(
  parameter int DIV_CLKS    = 10,
  parameter int LINE_PIXELS = 416,
  parameter int ADDR_W      = 16,
  parameter int FB_BASE     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              line_active,
  output logic              fb_rd_en,
  output logic [ADDR_W-1:0] fb_rd_addr,
  input  logic [7:0]        fb_rd_data,
  input  logic              pal_we,
  input  logic [3:0]        pal_idx,
  input  logic [7:0]        pal_color,
  output logic [7:0]        pix_color,
  output logic              pix_valid
);
  localparam int LINE_BYTES = LINE_PIXELS / 2;
  localparam int CNT_W      = $clog2(LINE_PIXELS + 1);

  logic             pe, in_win, take, more;
  logic [CNT_W-1:0] pix_cnt;
  nib_t             nibble;
  color_t           lut_color;

  pps_tick #(.DIV_CLKS(DIV_CLKS)) u_tick (
    .clk(clk), .rst_n(rst_n), .pe(pe)
  );

  pps_palette #(.ENTRIES(16)) u_pal (
    .clk(clk), .rst_n(rst_n), .we(pal_we), .wr_idx(pal_idx),
    .wr_color(pal_color), .rd_idx(nibble), .rd_color(lut_color)
  );

  pps_fetch #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .FB_BASE(FB_BASE)) u_fetch (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .adv(take), .more(more), .fb_rd_en(fb_rd_en), .fb_rd_addr(fb_rd_addr),
    .fb_rd_data(fb_rd_data), .nibble(nibble)
  );

  assign in_win = line_active && (int'(pix_cnt) < LINE_PIXELS);
  assign take   = pe && in_win;
  assign more   = (int'(pix_cnt) + 2) < LINE_PIXELS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_cnt   <= '0;
      pix_color <= '0;
      pix_valid <= 1'b0;
    end else begin
      if (pe) begin
        pix_color <= in_win ? lut_color : '0;
        pix_valid <= in_win;
        if (in_win) pix_cnt <= pix_cnt + CNT_W'(1);
      end
      if (line_start) pix_cnt <= '0;
    end
  end

  // R5: an idle output is black
  a_r5_black_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> pix_color == 8'h00);
  // R1: the output word moves only on a pixel-enable edge
  a_r1_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pe) |-> $stable(pix_color) && $stable(pix_valid));
  // R2: a visible pixel starts only while the line is active
  a_r2_valid_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid) |-> $past(line_active));
endmodule

// File: tb/pal_pixel_streamer_tb.sv
`timescale 1ns/1ps
module pal_pixel_streamer_tb;
  localparam int DIV  = 4;
  localparam int W    = 12;
  localparam int LB   = W / 2;
  localparam int AW   = 12;
  localparam int BASE = 'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 0, line_start = 0, line_active = 0;
  logic fb_rd_en;
  logic [AW-1:0] fb_rd_addr;
  logic [7:0] fb_rd_data = '0;
  logic pal_we = 0;
  logic [3:0] pal_idx = '0;
  logic [7:0] pal_color = '0;
  logic [7:0] pix_color;
  logic pix_valid;

  always #4 clk = ~clk;

  pal_pixel_streamer #(.DIV_CLKS(DIV), .LINE_PIXELS(W), .ADDR_W(AW), .FB_BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .line_active(line_active), .fb_rd_en(fb_rd_en), .fb_rd_addr(fb_rd_addr),
    .fb_rd_data(fb_rd_data), .pal_we(pal_we), .pal_idx(pal_idx), .pal_color(pal_color),
    .pix_color(pix_color), .pix_valid(pix_valid)
  );

  // Framebuffer RAM: data one cycle after the strobe (R7)
  logic [7:0] mem [1 << AW];
  always @(posedge clk) if (fb_rd_en) fb_rd_data <= mem[fb_rd_addr];

  int checks = 0, errors = 0;
  bit done = 0;
  string ph = "";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, updated on each rising edge
  int m_cnt = 0, m_line_next = 0, m_line_cur = 0, m_pix = 0;
  int exp_color = 0, exp_valid = 0, exp_addr = 0, rd_count = 0;
  bit m_first = 0, m_odd = 0, m_pe = 0, rd_first = 0;
  int pal_m [16];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_line_next = 0; m_pix = W; exp_color = 0; exp_valid = 0; m_pe = 0;
      for (int i = 0; i < 16; i++) pal_m[i] = i * 17;
    end else begin
      m_pe = (m_cnt == DIV - 1);
      m_cnt = m_pe ? 0 : m_cnt + 1;
      if (m_pe) begin
        if (line_active && m_pix < W) begin
          int b;
          b = mem[BASE + m_line_cur * LB + m_pix / 2];
          exp_color = pal_m[(m_pix % 2) ? (b >> 4) & 15 : b & 15];
          exp_valid = 1;
          m_first = (m_pix == 0);
          m_odd = (m_pix % 2) == 1;
          m_pix++;
        end else begin
          exp_color = 0; exp_valid = 0;
        end
      end
      if (frame_start) m_line_next = 0;
      if (line_start) begin
        m_line_cur = m_line_next;
        m_line_next++;
        m_pix = 0;
        exp_addr = BASE + m_line_cur * LB;
        rd_first = 1;
      end
      if (pal_we) pal_m[pal_idx] = pal_color;
    end
  end

  // Compare away from the active edge
  logic [7:0] last_color = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      string tag;
      if (!exp_valid) tag = "R5";
      else if (ph != "") tag = ph;
      else if (m_first) tag = "R2";
      else if (m_odd) tag = "R3";
      else tag = "R4";
      chk(pix_color == exp_color[7:0], {tag, " colour"}, pix_color, exp_color);
      chk(pix_valid == exp_valid[0], {tag, " valid"}, pix_valid, exp_valid);
      if (!m_pe) chk(pix_color == last_color, "R1 change off enable", pix_color, last_color);
      if (fb_rd_en) begin
        chk(fb_rd_addr == exp_addr[AW-1:0], rd_first ? "R6 line address" : "R7 step address",
            fb_rd_addr, exp_addr);
        exp_addr++; rd_count++; rd_first = 0;
      end
    end
    last_color = pix_color;
  end

  task automatic run_line(input bit fs, input int act_cycles, input bit full);
    @(negedge clk);
    rd_count = 0;
    line_start = 1; frame_start = fs;
    @(negedge clk);
    line_start = 0; frame_start = 0;
    repeat (4) @(negedge clk);
    line_active = 1;
    repeat (act_cycles) @(negedge clk);
    line_active = 0;
    repeat (2 * DIV) @(negedge clk);
    if (full) chk(rd_count == LB, "R7 read count", rd_count, LB);
  endtask

  initial begin
    for (int a = 0; a < (1 << AW); a++) mem[a] = 8'((a * 37 + 5) ^ (a >> 3));
    repeat (3) @(negedge clk);
    chk(pix_color == 0, "R9 reset colour", pix_color, 0);
    chk(pix_valid == 0, "R9 reset valid", pix_valid, 0);
    chk(fb_rd_en == 0, "R9 reset read", fb_rd_en, 0);
    rst_n = 1;
    ph = "R9";
    run_line(1, W * DIV + 3 * DIV, 1);
    ph = "";
    run_line(0, W * DIV + 3 * DIV, 1);
    run_line(0, W * DIV + 2 * DIV + 1, 1);
    run_line(0, 5 * DIV + 1, 0);           // R5 line cut short
    ph = "R8";
    fork
      run_line(0, W * DIV + 3 * DIV, 1);
      begin
        repeat (7) @(negedge clk);
        for (int i = 0; i < 16; i++) begin
          pal_we = 1; pal_idx = 4'(i); pal_color = 8'(i * 29 + 3);
          @(negedge clk);
          pal_we = 0;
          repeat (2 + i % 3) @(negedge clk);
        end
      end
    join
    run_line(0, W * DIV + 3 * DIV, 1);
    ph = "";
    // R6: separate frame start, then line 0 again
    @(negedge clk); frame_start = 1; @(negedge clk); frame_start = 0;
    repeat (3) @(negedge clk);
    run_line(0, W * DIV + 3 * DIV, 1);
    run_line(0, W * DIV + 3 * DIV, 1);
    repeat (10) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule